// File: doc/BRIEF.md
# Serial Transceiver with Infrared Pulse Mode

This block is an asynchronous serial transceiver controlled over a small synchronous register bus. The CPU writes bytes into a 16-entry transmit queue; the transmitter turns each one into a serial frame on `ser_out`. Frames arriving on `ser_in` are checked for parity, stop bit and line break, and their data is placed in a 16-entry receive queue for the CPU to read. A 16-bit divisor sets the oversampling tick. Each bit lasts sixteen ticks, and the receiver samples in the middle of each bit.

The character format can be set at run time: 5 to 8 data bits, an optional parity bit that is even or odd, and a long stop period. Hardware flow control holds the transmitter back while `cts_n` is high and raises `rts_n` when the receive queue is almost full. Setting the infrared bit replaces the plain line with return-to-zero pulses, and the receiver decodes them. A single interrupt line reports the highest-priority pending cause, and the CPU can read which cause it is.

The registers sit at these bus offsets. 0 is data: a write queues a byte and a read pops a byte. 1 is interrupt enable: bit0 received data, bit1 transmit queue empty, bit2 line status. 2 is the read-only interrupt ident. 3 is format. 4 and 5 are the low and high bytes of the divisor. 6 is the read-only line status.

Top module: `uart_sir_core`

## Requirements
- R1: After reset the format register reads 0x03, line status reads 0x60, interrupt ident reads 0, `irq` is low, `ser_out` is high and `rts_n` is low.
- R2: Format bits [1:0] give the data length minus 5. Data is sent least significant bit first, and a received byte reads back with every bit above the data length at 0.
- R3: Format bit3 enables a parity bit after the data, and bit4 chooses even parity (1) or odd parity (0). A received parity mismatch sets line status bit2.
- R4: Format bit2 selects the long stop period. With 5 data bits it lasts 24 ticks; with any other length it lasts 32 ticks. With bit2 clear it lasts 16 ticks. Queued frames are sent back to back.
- R5: One tick equals the divisor in clock cycles, and a divisor of 0 acts as 1. Each start, data and parity bit lasts 16 ticks.
- R6: Each queue holds 16 bytes. A frame received while the receive queue is full is dropped and sets line status bit1 (overrun).
- R7: With format bit7 (flow control) set, no new frame starts while `cts_n` is high.
- R8: With flow control set, `rts_n` is high while the receive queue holds 14 or more bytes, and low otherwise. With flow control clear it stays low.
- R9: While format bit5 (break) is set in plain mode, `ser_out` is held low.
- R10: A received frame whose data bits, parity bit and stop bit are all 0 sets line status bit4 (break) and bit3, and queues the byte 0x00.
- R11: With format bit6 set, each 0 bit is sent as a high pulse during the first 3 ticks of the bit and each 1 bit is sent as low, so the idle line is low. The receiver decodes such pulses.
- R12: The interrupt ident is 1 for a pending line error when bit2 is enabled. Otherwise it is 2 for received data when bit0 is enabled, otherwise 3 for an empty transmit queue when bit1 is enabled, otherwise 0. `irq` is high exactly when the ident is nonzero.
- R13: Line status bit0 shows received data, bit5 shows an empty transmit queue, and bit6 shows the transmitter fully idle. A read of line status clears bits 1 to 4.
- R14: A stop bit sampled as 0 sets line status bit3 (framing error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| cts_n | input | 1 | Peer ready to receive, active low |
| rts_n | output | 1 | Request to hold transmission, active high to stop |

## Verification
Round trips through a loopback run over a table of formats. The table covers every data length, both parities, all three stop lengths and infrared mode, so that truncation and parity placement can be told apart. Frame timing is measured as the spacing between start edges. The data are all ones, so the only falling edge in each frame is the start bit, and the spacing isolates the stop-period length and the divisor. Hand-driven frames with a wrong parity bit, a zero stop bit or an all-zero break show whether each error is flagged separately. A burst of seventeen frames fills the receive queue past its limit and exercises the overrun flag, the `rts_n` threshold on both sides and the ordering of interrupt causes.

// File: rtl/uart_sir_pkg.sv
// Shared types and constants for the serial transceiver.
// Assumes the format register layout fixed in the brief (bit7 down to bit0).
package uart_sir_pkg;

    localparam int DIV_W = 16;

    typedef struct packed {
        logic       flow_en;
        logic       sir_en;
        logic       brk;
        logic       par_even;
        logic       par_en;
        logic       stop_x;
        logic [1:0] len;
    } fmt_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITH} rx_state_t;

    localparam logic [1:0] IID_NONE = 2'd0;
    localparam logic [1:0] IID_LINE = 2'd1;
    localparam logic [1:0] IID_RXD  = 2'd2;
    localparam logic [1:0] IID_THR  = 2'd3;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_IEN  = 3'd1;
    localparam logic [2:0] A_IID  = 3'd2;
    localparam logic [2:0] A_FMT  = 3'd3;
    localparam logic [2:0] A_DIVL = 3'd4;
    localparam logic [2:0] A_DIVH = 3'd5;
    localparam logic [2:0] A_STAT = 3'd6;

    // Mask keeping the low (len+5) bits of a byte.
    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/uart_sir_fifo.sv
// Synchronous first-in first-out queue with a show-ahead read port.
// Assumes DEPTH is a power of two; callers never push when full or pop when empty.
module uart_sir_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;

    assign dout = mem[rp];

    // Storage write, no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && count == (AW+1)'(DEPTH)));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && count == '0));

endmodule

// File: rtl/uart_sir_baud.sv
// Oversampling tick generator: one-cycle pulse every max(div,1) clocks.
// Assumes div may change at any time; the new value takes effect at the next reload.
module uart_sir_baud #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    // Down-counter with reload; the tick is registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == '0);
            if (cnt == '0) cnt <= (div == '0) ? '0 : div - 1'b1;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/uart_sir_tx.sv
// Frame serializer: start, 5..8 data bits LSB first, optional parity, stop period
// of 16, 24 or 32 ticks; optional break and return-to-zero pulse output.
// Assumes tick is a one-cycle pulse and din is valid whenever has_data is high.
module uart_sir_tx
    import uart_sir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  fmt_t       fmt,
    input  logic       has_data,
    input  logic       allow,
    input  logic [7:0] din,
    output logic       pop,
    output logic       ser_out,
    output logic       busy
);
    tx_state_t  state;
    logic [4:0] sub;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       par_bit;
    logic       line_bit, nrz, pulse;
    logic       bit_end, stop_end, last_bit;
    logic [4:0] stop_last;
    logic [7:0] din_m;

    // Decode of the current bit position and stop length.
    always_comb begin
        stop_last = !fmt.stop_x ? 5'd15 : ((fmt.len == 2'd0) ? 5'd23 : 5'd31);
        bit_end   = (sub[3:0] == 4'hF);
        stop_end  = (sub == stop_last);
        last_bit  = (bitn == (3'd4 + {1'b0, fmt.len}));
        din_m     = din & len_mask(fmt.len);
        pop       = tick && has_data && allow &&
                    (state == TX_IDLE || (state == TX_STOP && stop_end));
    end

    // Line level for the current state, then break and pulse shaping.
    always_comb begin
        case (state)
            TX_START: line_bit = 1'b0;
            TX_DATA:  line_bit = shreg[0];
            TX_PAR:   line_bit = par_bit;
            default:  line_bit = 1'b1;
        endcase
        nrz   = fmt.brk ? 1'b0 : line_bit;
        pulse = !nrz && (sub[3:0] < 4'd3);
    end

    assign busy = (state != TX_IDLE);

    // Frame sequencer, advancing on ticks; output registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            sub     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            ser_out <= 1'b1;
        end else begin
            ser_out <= fmt.sir_en ? pulse : nrz;
            if (pop) begin
                state   <= TX_START;
                sub     <= '0;
                shreg   <= din_m;
                par_bit <= (^din_m) ^ !fmt.par_even;
            end else if (tick) begin
                case (state)
                    TX_IDLE: sub <= {1'b0, sub[3:0] + 4'd1};
                    TX_START: begin
                        if (bit_end) begin
                            sub   <= '0;
                            bitn  <= '0;
                            state <= TX_DATA;
                        end else sub <= sub + 5'd1;
                    end
                    TX_DATA: begin
                        if (bit_end) begin
                            sub   <= '0;
                            shreg <= shreg >> 1;
                            if (last_bit) state <= fmt.par_en ? TX_PAR : TX_STOP;
                            else          bitn  <= bitn + 3'd1;
                        end else sub <= sub + 5'd1;
                    end
                    TX_PAR: begin
                        if (bit_end) begin
                            sub   <= '0;
                            state <= TX_STOP;
                        end else sub <= sub + 5'd1;
                    end
                    TX_STOP: begin
                        if (stop_end) begin
                            sub   <= '0;
                            state <= TX_IDLE;
                        end else sub <= sub + 5'd1;
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt.brk && !fmt.sir_en) |=> !ser_out);
    assert_sir_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt.sir_en && sub[3:0] >= 4'd3) |=> !ser_out);

endmodule

// File: rtl/uart_sir_rx.sv
// Frame deserializer: synchronizes the line, optionally stretches return-to-zero
// pulses back into plain levels, samples each bit at mid-point and reports one
// byte with parity, framing and break flags per frame.
// Assumes tick is a one-cycle pulse at 16 times the bit rate.
module uart_sir_rx
    import uart_sir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  fmt_t       fmt,
    input  logic       line_in,
    output logic       push,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr,
    output logic       brk
);
    logic       s1, s2, s_prev;
    logic [4:0] hold;
    logic       nrz;
    rx_state_t  state;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       par_acc, par_bad, all_zero;
    logic       last_bit;

    // Two-stage synchronizer plus previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s1     <= line_in;
            s2     <= s1;
            s_prev <= s2;
        end
    end

    // Pulse stretcher: a rising pulse edge holds the decoded line low for 17 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !fmt.sir_en)     hold <= '0;
        else if (s2 && !s_prev)        hold <= 5'd17;
        else if (tick && hold != '0)   hold <= hold - 5'd1;
    end

    assign nrz      = fmt.sir_en ? (hold == '0) : s2;
    assign last_bit = (bitn == (3'd4 + {1'b0, fmt.len}));

    // Receive sequencer with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            sub      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            all_zero <= 1'b1;
            push     <= 1'b0;
            data     <= '0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
            brk      <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: if (!nrz) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                    RX_START: begin
                        if (sub == 4'd7) begin
                            sub      <= '0;
                            bitn     <= '0;
                            par_acc  <= 1'b0;
                            par_bad  <= 1'b0;
                            all_zero <= 1'b1;
                            state    <= nrz ? RX_IDLE : RX_DATA;
                        end else sub <= sub + 4'd1;
                    end
                    RX_DATA: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'hF) begin
                            shreg    <= {nrz, shreg[7:1]};
                            par_acc  <= par_acc ^ nrz;
                            all_zero <= all_zero & !nrz;
                            if (last_bit) state <= fmt.par_en ? RX_PAR : RX_STOP;
                            else          bitn  <= bitn + 3'd1;
                        end
                    end
                    RX_PAR: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'hF) begin
                            par_bad  <= ((par_acc ^ nrz) != !fmt.par_even);
                            all_zero <= all_zero & !nrz;
                            state    <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'hF) begin
                            push  <= 1'b1;
                            data  <= shreg >> (2'd3 - fmt.len);
                            perr  <= par_bad;
                            ferr  <= !nrz;
                            brk   <= !nrz && all_zero;
                            state <= nrz ? RX_IDLE : RX_WAITH;
                        end
                    end
                    RX_WAITH: if (nrz) state <= RX_IDLE;
                    default:  state <= RX_IDLE;
                endcase
            end
        end
    end

    assert_push_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(state) == RX_STOP));

endmodule

// File: rtl/uart_sir_core.sv
// Top level: register bus decode, queues, tick generator, transmitter, receiver,
// line status flags, flow control and prioritized interrupt ident.
// Assumes bus_sel is a one-cycle strobe; reads of data and status have side effects.
module uart_sir_core
    import uart_sir_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RTS_GAP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       ser_in,
    output logic       ser_out,
    input  logic       cts_n,
    output logic       rts_n
);
    localparam int         AW        = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT  = (AW+1)'(DEPTH);
    localparam logic [AW:0] RTS_LEVEL = (AW+1)'(DEPTH - RTS_GAP);

    fmt_t             fmt;
    logic [2:0]       ien;
    logic [DIV_W-1:0] div;
    logic             tick;
    logic             wr_en, rd_en;
    logic             ovr_f, perr_f, ferr_f, brk_f, err_any;
    logic             cts_s1, cts_s2;
    logic [AW:0]      tx_cnt, rx_cnt;
    logic [7:0]       tx_dout, rx_dout;
    logic             tx_push, tx_pop, tx_busy, tx_empty;
    logic             rx_push_raw, rx_push, rx_pop, rx_empty, rx_full;
    logic [7:0]       rx_data;
    logic             rx_perr, rx_ferr, rx_brk;
    logic [1:0]       iid;
    logic [7:0]       stat;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign tx_empty = (tx_cnt == '0);
    assign rx_empty = (rx_cnt == '0);
    assign rx_full  = (rx_cnt == FULL_CNT);
    assign tx_push  = wr_en && bus_addr == A_DATA && tx_cnt != FULL_CNT;
    assign rx_pop   = rd_en && bus_addr == A_DATA && !rx_empty;
    assign rx_push  = rx_push_raw && !rx_full;
    assign err_any  = ovr_f | perr_f | ferr_f | brk_f;

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt <= fmt_t'(8'h03);
            ien <= '0;
            div <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_IEN:  ien       <= bus_wdata[2:0];
                A_FMT:  fmt       <= fmt_t'(bus_wdata);
                A_DIVL: div[7:0]  <= bus_wdata;
                A_DIVH: div[15:8] <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Sticky line error flags, cleared by a status read; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ovr_f, perr_f, ferr_f, brk_f} <= '0;
        end else begin
            logic clr;
            clr    = rd_en && bus_addr == A_STAT;
            ovr_f  <= (rx_push_raw && rx_full) | (ovr_f  & !clr);
            perr_f <= (rx_push_raw && rx_perr) | (perr_f & !clr);
            ferr_f <= (rx_push_raw && rx_ferr) | (ferr_f & !clr);
            brk_f  <= (rx_push_raw && rx_brk)  | (brk_f  & !clr);
        end
    end

    // Clear-to-send synchronizer and request-to-send threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_s1 <= 1'b1;
            cts_s2 <= 1'b1;
            rts_n  <= 1'b0;
        end else begin
            cts_s1 <= cts_n;
            cts_s2 <= cts_s1;
            rts_n  <= fmt.flow_en && (rx_cnt >= RTS_LEVEL);
        end
    end

    // Interrupt cause selection in fixed priority order.
    always_comb begin
        if (ien[2] && err_any)         iid = IID_LINE;
        else if (ien[0] && !rx_empty)  iid = IID_RXD;
        else if (ien[1] && tx_empty)   iid = IID_THR;
        else                           iid = IID_NONE;
        irq  = (iid != IID_NONE);
        stat = {1'b0, tx_empty && !tx_busy, tx_empty, brk_f, ferr_f, perr_f, ovr_f, !rx_empty};
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = rx_empty ? 8'h00 : rx_dout;
            A_IEN:   bus_rdata = {5'b0, ien};
            A_IID:   bus_rdata = {6'b0, iid};
            A_FMT:   bus_rdata = fmt;
            A_DIVL:  bus_rdata = div[7:0];
            A_DIVH:  bus_rdata = div[15:8];
            A_STAT:  bus_rdata = stat;
            default: bus_rdata = 8'h00;
        endcase
    end

    uart_sir_baud #(.DW(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
    );

    uart_sir_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt)
    );

    uart_sir_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt)
    );

    uart_sir_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
        .has_data(!tx_empty), .allow(!fmt.flow_en || !cts_s2), .din(tx_dout),
        .pop(tx_pop), .ser_out(ser_out), .busy(tx_busy)
    );

    uart_sir_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .line_in(ser_in),
        .push(rx_push_raw), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr), .brk(rx_brk)
    );

    assert_cts_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!fmt.flow_en || !cts_s2));
    assert_line_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[2] && err_any) |-> (iid == IID_LINE && irq));

endmodule

// File: tb/uart_sir_core_tb.sv
module uart_sir_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, ser_out, rts_n;
    logic       cts_n = 1'b0;
    logic       loop = 1'b1;
    logic       bb_line = 1'b1;
    logic       ser_in;
    int         checks = 0;
    int         errors = 0;

    localparam int DIVV = 2;
    localparam int BITC = 16 * DIVV;
    // {format, data} pairs for loopback round trips.
    localparam logic [15:0] VEC [6] = '{16'h03A5, 16'h1ABC, 16'h04F5, 16'h0D2A, 16'h435B, 16'h1FFF};

    assign ser_in = loop ? ser_out : bb_line;

    always #2 clk = ~clk;

    uart_sir_core u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ser_in(ser_in), .ser_out(ser_out), .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_rx(output bit ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            rd(3'd6, s);
            if (s[0]) begin ok = 1'b1; break; end
            repeat (20) @(negedge clk);
        end
    endtask

    task automatic drain();
        logic [7:0] s, d;
        repeat (700) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            rd(3'd6, s);
            if (!s[0]) break;
            rd(3'd0, d);
        end
    endtask

    // Cycles between two successive falling edges on ser_out.
    task automatic gap(output int g);
        int c = 0;
        @(negedge clk);
        while (ser_out !== 1'b0) @(negedge clk);
        while (ser_out === 1'b0) begin @(negedge clk); c++; end
        while (ser_out === 1'b1) begin @(negedge clk); c++; end
        g = c;
    endtask

    // Drive a frame by hand, LSB first, one bit per BITC cycles.
    task automatic bang(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bb_line = bits[i];
            repeat (BITC - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, s;
        bit ok;
        int g;
        logic [7:0] exp_d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 ser_out", int'(ser_out), 1);
        chk("R1 rts_n", int'(rts_n), 0);
        chk("R1 irq", int'(irq), 0);
        rd(3'd3, d); chk("R1 format", d, 8'h03);
        rd(3'd6, d); chk("R1 status", d, 8'h60);
        rd(3'd2, d); chk("R1 ident", d, 0);

        wr(3'd4, DIVV[7:0]);

        // Table walk: R2 lengths, R3 parity, R4 stop, R11 pulse mode round trip
        for (int v = 0; v < 6; v++) begin
            wr(3'd3, VEC[v][15:8]);
            repeat (100) @(negedge clk);
            wr(3'd0, VEC[v][7:0]);
            wait_rx(ok);
            chk("R2 frame received", int'(ok), 1);
            rd(3'd0, d);
            exp_d = VEC[v][7:0] & 8'((1 << (int'(VEC[v][9:8]) + 5)) - 1);
            chk("R2 R3 R11 data", d, exp_d);
            repeat (100) @(negedge clk);
            rd(3'd6, s); chk("R13 status clean", s, 8'h60);
        end

        // R4 stop periods, measured as start-to-start spacing (data all ones)
        cts_n = 1'b1;
        wr(3'd3, 8'h84);
        wr(3'd0, 8'h1F); wr(3'd0, 8'h1F);
        cts_n = 1'b0;
        gap(g); chk("R4 5-bit long stop 24 ticks", g, 120 * DIVV);
        drain();
        cts_n = 1'b1;
        wr(3'd3, 8'h87);
        wr(3'd0, 8'hFF); wr(3'd0, 8'hFF);
        cts_n = 1'b0;
        gap(g); chk("R4 8-bit long stop 32 ticks", g, 176 * DIVV);
        drain();
        // R5 divisor scaling and divisor 0
        cts_n = 1'b1;
        wr(3'd3, 8'h83);
        wr(3'd0, 8'hFF); wr(3'd0, 8'hFF);
        cts_n = 1'b0;
        gap(g); chk("R5 bit time 16 ticks of divisor", g, 160 * DIVV);
        drain();
        wr(3'd4, 8'h00);
        cts_n = 1'b1;
        wr(3'd0, 8'hFF); wr(3'd0, 8'hFF);
        cts_n = 1'b0;
        gap(g); chk("R5 divisor zero acts as one", g, 160);
        drain();
        wr(3'd4, DIVV[7:0]);

        // R11 pulse width and idle level
        cts_n = 1'b1;
        wr(3'd3, 8'hC3);
        repeat (10) @(negedge clk);
        chk("R11 idle low", int'(ser_out), 0);
        wr(3'd0, 8'h00);
        cts_n = 1'b0;
        g = 0;
        while (ser_out !== 1'b1) @(negedge clk);
        while (ser_out === 1'b1) begin @(negedge clk); g++; end
        chk("R11 pulse 3 ticks", g, 3 * DIVV);
        drain();

        // R9 break generation, R10 break detection, R13 clear on read
        wr(3'd3, 8'h23);
        repeat (20) @(negedge clk);
        chk("R9 line low during break", int'(ser_out), 0);
        repeat (800) @(negedge clk);
        chk("R9 line still low", int'(ser_out), 0);
        wr(3'd3, 8'h03);
        repeat (300) @(negedge clk);
        rd(3'd6, s); chk("R10 break and framing flags", s, 8'h79);
        rd(3'd0, d); chk("R10 break char", d, 8'h00);
        rd(3'd6, s); chk("R13 flags cleared", s, 8'h60);

        // R3 parity mismatch, hand-driven: 8 bits even parity, data 0x01, parity 0
        loop = 1'b1; bb_line = 1'b1;
        wr(3'd3, 8'h1B);
        loop = 1'b0;
        repeat (50) @(negedge clk);
        bang({1'b1, 1'b0, 8'h01, 1'b0}, 11);
        repeat (100) @(negedge clk);
        rd(3'd6, s); chk("R3 parity error", s, 8'h65);
        rd(3'd0, d); chk("R3 data kept", d, 8'h01);
        // R14 stop bit zero, data nonzero
        wr(3'd3, 8'h03);
        bang({1'b0, 8'h55, 1'b0}, 10);
        bb_line = 1'b1;
        repeat (100) @(negedge clk);
        rd(3'd6, s); chk("R14 framing error", s, 8'h69);
        rd(3'd0, d); chk("R14 data", d, 8'h55);
        loop = 1'b1;
        repeat (50) @(negedge clk);

        // R7 transmission held while cts_n high
        cts_n = 1'b1;
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h33);
        ok = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (ser_out !== 1'b1) ok = 1'b0;
        end
        chk("R7 no start while blocked", int'(ok), 1);
        rd(3'd6, s); chk("R7 queue held", s, 8'h00);
        cts_n = 1'b0;
        wait_rx(ok);
        rd(3'd0, d); chk("R7 sent after release", d, 8'h33);
        repeat (100) @(negedge clk);

        // R6 overrun, R8 request-to-send threshold, R12 priority
        chk("R8 low when empty", int'(rts_n), 0);
        for (int i = 1; i <= 17; i++) wr(3'd0, 8'(i));
        repeat (17 * 160 * DIVV + 600) @(negedge clk);
        chk("R8 high when full", int'(rts_n), 1);
        wr(3'd1, 8'h07);
        rd(3'd2, d); chk("R12 line error first", d, 1);
        chk("R12 irq high", int'(irq), 1);
        rd(3'd6, s); chk("R6 overrun flag", s, 8'h63);
        rd(3'd2, d); chk("R12 received data next", d, 2);
        rd(3'd0, d); chk("R6 first byte", d, 8'h01);
        rd(3'd0, d);
        repeat (3) @(negedge clk);
        chk("R8 still high at 14", int'(rts_n), 1);
        rd(3'd0, d);
        repeat (3) @(negedge clk);
        chk("R8 low at 13", int'(rts_n), 0);
        for (int i = 4; i <= 15; i++) rd(3'd0, d);
        rd(3'd0, d); chk("R6 sixteenth byte kept", d, 8'h10);
        rd(3'd6, s); chk("R6 seventeenth dropped", s, 8'h60);
        rd(3'd2, d); chk("R12 transmit empty last", d, 3);
        wr(3'd1, 8'h00);
        rd(3'd2, d); chk("R12 none when disabled", d, 0);
        chk("R12 irq low", int'(irq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule